// File: doc/BRIEF.md
# Command-Driven Global Control Register with Buffer Access Gate

This block holds the global control word of a bus-controller module. Software never edits the enable bits by read-modify-write. Instead, each write carries command bits: one bit turns the operating-mode enable on, another turns it off, and a third turns the forced-shutdown enable on. The command bits sit in different positions from the bits that a read returns.

From the operating-mode enable and the low-power inputs (sleep and stop), the block keeps a read-only buffer-access flag. The flag drives a registered gate. While the gate is closed, bus accesses to the message-buffer window and to the history registers are held back: writes are dropped and reads return zero.

The mode is tracked by a three-state machine:
- `ST_OFF`: the operating-mode enable is 0.
- `ST_RUN`: the enable is 1 and no low-power mode is active. The gate is open only in this state.
- `ST_LOWPWR`: the enable is 1 and sleep or stop is high.

The transitions are:
- `ST_OFF` to `ST_RUN` on an enable-set command with no low-power input.
- `ST_OFF` to `ST_LOWPWR` on an enable-set command while low power is active.
- `ST_RUN` to `ST_LOWPWR` when low power is entered.
- `ST_LOWPWR` to `ST_RUN` when low power is released.
- `ST_RUN` or `ST_LOWPWR` to `ST_OFF` on an enable-clear command.

Top module: `gctl_top`

## Requirements
- R1: After reset, a read of the control word (address 0x000) returns 0x0000, and `gate_open` is 0.
- R2: A read at address 0x000 returns the following layout. Bit 15 is the buffer-access flag, bit 1 is the forced-shutdown enable and bit 0 is the operating-mode enable. Every other bit reads 0.
- R3: In a write to address 0x000, bit 8 set to 1 turns the operating-mode enable on and bit 0 set to 1 turns it off. Command bits that are 0 leave the state unchanged. When bits 8 and 0 are both 1, the enable keeps its previous value.
- R4: A write to address 0x000 with bit 9 set to 1 turns the forced-shutdown enable on. No write command turns it off.
- R5: Writing 1 to bit 15 of address 0x000 has no effect on the buffer-access flag.
- R6: An enable-set write made while `sleep_mode` and `stop_mode` are both 0 sets the flag and opens `gate_open` at the clock edge that ends the write cycle.
- R7: The flag and `gate_open` drop at the clock edge that follows an enable-clear write. They also drop at the clock edge after `sleep_mode` or `stop_mode` goes high.
- R8: When low power is released while the enable is 1, the flag and `gate_open` rise at the next clock edge.
- R9: The buffer window is 0x100 to 0x1FF and the history registers are 0x200 to 0x203.
  - While `gate_open` is 0, accesses to these ranges keep `buf_wr_en` and `buf_rd_en` at 0 and return 0 on `bus_rdata`.
  - While `gate_open` is 1, `buf_wr_en` follows `bus_wr` and `buf_rd_en` follows `bus_rd`, and `bus_rdata` carries `buf_rdata`.
- R10: The forced-shutdown enable clears at the clock edge that comes one cycle after the operating-mode enable goes from 1 to 0. At that edge, the clear wins over a set command made in the same cycle.
- R11: Reads at any other address return 0, and `bus_rdata` is 0 whenever `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| sleep_mode | input | 1 | Sleep mode active |
| stop_mode | input | 1 | Stop mode active |
| buf_rdata | input | 16 | Read data from the buffer and history storage |
| buf_wr_en | output | 1 | Gated write enable for the buffer and history storage |
| buf_rd_en | output | 1 | Gated read enable for the buffer and history storage |
| gate_open | output | 1 | Registered access gate (the buffer-access flag) |

## Verification
The hardest situation to reach is the one-cycle window after the operating-mode enable falls, when a forced-shutdown set command arrives in the same cycle as the automatic clear. The stimulus reaches it by issuing an enable-clear write followed back to back by a bit-9 write, with no idle cycle between them. Low-power entry and exit are also driven while the enable is both on and off, with gated reads and writes issued on either side of each transition. A behavioural model updated at every edge follows all of these cases.

// File: rtl/gctl_pkg.sv
package gctl_pkg;
    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 16;
    localparam int NUM_REGIONS = 2;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h000;

    localparam logic [ADDR_W-1:0] REGION_LO [NUM_REGIONS] = '{12'h100, 12'h200};
    localparam logic [ADDR_W-1:0] REGION_HI [NUM_REGIONS] = '{12'h1FF, 12'h203};

    // command bit positions in the write layout
    localparam int CMD_SET_GOM = 8;
    localparam int CMD_CLR_GOM = 0;
    localparam int CMD_SET_FSD = 9;

    // status bit positions in the read layout
    localparam int RD_FLAG = 15;
    localparam int RD_FSD  = 1;
    localparam int RD_GOM  = 0;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_LOWPWR = 2'd2
    } gctl_state_e;
endpackage

// File: rtl/gctl_cmd_decode.sv
module gctl_cmd_decode
    import gctl_pkg::*;
(
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ctrl_hit,
    output logic              set_gom,
    output logic              clr_gom,
    output logic              set_fsd
);
    logic wr_ctrl;
    logic unused_wbits;

    assign ctrl_hit = (bus_addr == CTRL_ADDR);
    assign wr_ctrl  = bus_wr && ctrl_hit;

    // set and clear together cancel out
    assign set_gom = wr_ctrl && bus_wdata[CMD_SET_GOM] && !bus_wdata[CMD_CLR_GOM];
    assign clr_gom = wr_ctrl && bus_wdata[CMD_CLR_GOM] && !bus_wdata[CMD_SET_GOM];
    assign set_fsd = wr_ctrl && bus_wdata[CMD_SET_FSD];

    assign unused_wbits = ^{bus_wdata[DATA_W-1:CMD_SET_FSD+1],
                            bus_wdata[CMD_SET_GOM-1:CMD_CLR_GOM+1]};
endmodule

// File: rtl/gctl_mode_fsm.sv
module gctl_mode_fsm
    import gctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_gom,
    input  logic clr_gom,
    input  logic set_fsd,
    input  logic low_power,
    output logic gom,
    output logic fsd,
    output logic gate_q
);
    gctl_state_e state_q, state_nx;
    logic        gom_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (set_gom) state_nx = low_power ? ST_LOWPWR : ST_RUN;
            end
            ST_RUN: begin
                if (clr_gom)        state_nx = ST_OFF;
                else if (low_power) state_nx = ST_LOWPWR;
            end
            ST_LOWPWR: begin
                if (clr_gom)         state_nx = ST_OFF;
                else if (!low_power) state_nx = ST_RUN;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    assign gom = (state_q != ST_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            gom_d  <= 1'b0;
            fsd    <= 1'b0;
        end else begin
            gate_q <= (state_nx == ST_RUN);
            gom_d  <= gom;
            if (gom_d && !gom)  fsd <= 1'b0;
            else if (set_fsd)   fsd <= 1'b1;
        end
    end

    a_r3_both_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_gom && !clr_gom) |=> $stable(gom));
    a_r6_set_opens_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (set_gom && !low_power) |=> gate_q);
    a_r7_low_power_closes: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |=> !gate_q);
    a_r7_clear_closes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_gom |=> (!gate_q && !gom));
    a_r10_fsd_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gom) |=> !fsd);
endmodule

// File: rtl/gctl_access_gate.sv
module gctl_access_gate
    import gctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              ctrl_hit,
    input  logic              gate,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              buf_wr_en,
    output logic              buf_rd_en,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [NUM_REGIONS-1:0] hit_vec;
    logic                   region_hit;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        assign hit_vec[g] = (bus_addr >= REGION_LO[g]) && (bus_addr <= REGION_HI[g]);
    end

    assign region_hit = |hit_vec;
    assign buf_wr_en  = bus_wr && region_hit && gate;
    assign buf_rd_en  = bus_rd && region_hit && gate;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (ctrl_hit)       bus_rdata = ctrl_word;
            else if (buf_rd_en) bus_rdata = buf_rdata;
        end
    end

    a_r9_closed_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> (!buf_wr_en && !buf_rd_en));
    a_r9_regions_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: rtl/gctl_top.sv
module gctl_top
    import gctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              sleep_mode,
    input  logic              stop_mode,
    input  logic [15:0]       buf_rdata,
    output logic              buf_wr_en,
    output logic              buf_rd_en,
    output logic              gate_open
);
    logic ctrl_hit, set_gom, clr_gom, set_fsd;
    logic gom, fsd, gate_q;
    logic [DATA_W-1:0] ctrl_word;

    gctl_cmd_decode u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctrl_hit  (ctrl_hit),
        .set_gom   (set_gom),
        .clr_gom   (clr_gom),
        .set_fsd   (set_fsd)
    );

    gctl_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_gom   (set_gom),
        .clr_gom   (clr_gom),
        .set_fsd   (set_fsd),
        .low_power (sleep_mode || stop_mode),
        .gom       (gom),
        .fsd       (fsd),
        .gate_q    (gate_q)
    );

    always_comb begin
        ctrl_word          = '0;
        ctrl_word[RD_FLAG] = gate_q;
        ctrl_word[RD_FSD]  = fsd;
        ctrl_word[RD_GOM]  = gom;
    end

    gctl_access_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .ctrl_hit  (ctrl_hit),
        .gate      (gate_q),
        .ctrl_word (ctrl_word),
        .buf_rdata (buf_rdata),
        .buf_wr_en (buf_wr_en),
        .buf_rd_en (buf_rd_en),
        .bus_rdata (bus_rdata)
    );

    assign gate_open = gate_q;

    a_r5_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> (bus_rdata[0] || !(bus_rd && ctrl_hit)));
endmodule

// File: tb/test_gctl_top.sv
module test_gctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sleep_mode = 1'b0;
    logic        stop_mode = 1'b0;
    logic [15:0] buf_rdata;
    logic        buf_wr_en, buf_rd_en, gate_open;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign buf_rdata = {4'hA, bus_addr};

    gctl_top i_gctl_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sleep_mode(sleep_mode), .stop_mode(stop_mode), .buf_rdata(buf_rdata),
        .buf_wr_en(buf_wr_en), .buf_rd_en(buf_rd_en), .gate_open(gate_open)
    );

    // reference model
    bit m_gom = 0, m_fsd = 0, m_flag = 0, m_gom_prev = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_gom = 0; m_fsd = 0; m_flag = 0; m_gom_prev = 0;
        end else begin
            bit wr_ctrl, lp, n_gom, n_fsd;
            wr_ctrl = bus_wr && (bus_addr == 12'h000);
            lp = sleep_mode || stop_mode;
            n_gom = m_gom;
            if (wr_ctrl && bus_wdata[8] && !bus_wdata[0]) n_gom = 1;
            if (wr_ctrl && bus_wdata[0] && !bus_wdata[8]) n_gom = 0;
            n_fsd = m_fsd;
            if (m_gom_prev && !m_gom) n_fsd = 0;
            else if (wr_ctrl && bus_wdata[9]) n_fsd = 1;
            m_gom_prev = m_gom;
            m_gom = n_gom;
            m_fsd = n_fsd;
            m_flag = n_gom && !lp;
        end
    end

    function automatic bit in_region(logic [11:0] a);
        return (a >= 12'h100 && a <= 12'h1FF) || (a >= 12'h200 && a <= 12'h203);
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] exp_rd;
            bit open;
            open = m_flag;
            exp_rd = '0;
            if (bus_rd) begin
                if (bus_addr == 12'h000) exp_rd = {m_flag, 13'b0, m_fsd, m_gom};
                else if (in_region(bus_addr) && open) exp_rd = buf_rdata;
            end
            check("R7 gate_open", {15'b0, gate_open}, {15'b0, open});
            check("R9 buf_wr_en", {15'b0, buf_wr_en}, {15'b0, bus_wr && in_region(bus_addr) && open});
            check("R9 buf_rd_en", {15'b0, buf_rd_en}, {15'b0, bus_rd && in_region(bus_addr) && open});
            check("R2 bus_rdata", bus_rdata, exp_rd);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [11:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1; step(); bus_wr = 0;
    endtask

    task automatic rd_check(logic [11:0] a, logic [15:0] exp, string tag);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        step();
        bus_rd = 0;
    endtask

    task automatic gate_check(bit exp, string tag);
        @(negedge clk);
        check(tag, {15'b0, gate_open}, {15'b0, exp});
        step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        rd_check(12'h000, 16'h0000, "R1 reset value");
        gate_check(0, "R1 gate closed after reset");
        // gated while closed
        rd_check(12'h140, 16'h0000, "R9 blocked buffer read");
        bus_addr = 12'h202; bus_wr = 1;
        @(negedge clk); check("R9 blocked history write", {15'b0, buf_wr_en}, 16'h0); step(); bus_wr = 0;
        // enable on
        wr(12'h000, 16'h0100);
        gate_check(1, "R6 gate opens after set");
        rd_check(12'h000, 16'h8001, "R3 set operating enable");
        wr(12'h000, 16'h8000);
        rd_check(12'h000, 16'h8001, "R5 write to flag ignored");
        wr(12'h000, 16'h0000);
        rd_check(12'h000, 16'h8001, "R3 zero command no change");
        wr(12'h000, 16'h0200);
        rd_check(12'h000, 16'h8003, "R4 forced shutdown set");
        rd_check(12'h1FF, 16'hA1FF, "R9 open buffer read");
        rd_check(12'h203, 16'hA203, "R9 open history read");
        rd_check(12'h300, 16'h0000, "R11 unmapped read");
        rd_check(12'h204, 16'h0000, "R11 past history read");
        // sleep entry and exit
        sleep_mode = 1; step();
        rd_check(12'h000, 16'h0003, "R7 sleep clears flag");
        rd_check(12'h100, 16'h0000, "R9 blocked during sleep");
        sleep_mode = 0; step();
        rd_check(12'h000, 16'h8003, "R8 sleep release sets flag");
        stop_mode = 1; step();
        gate_check(0, "R7 stop closes gate");
        stop_mode = 0; step();
        gate_check(1, "R8 stop release opens gate");
        wr(12'h000, 16'h0101);
        rd_check(12'h000, 16'h8003, "R3 set and clear together hold");
        // clear enable; fsd clears one cycle later
        bus_addr = 12'h000; bus_wdata = 16'h0001; bus_wr = 1; step(); bus_wr = 0;
        bus_rd = 1;
        @(negedge clk); check("R7 clear drops flag", bus_rdata, 16'h0002);
        step();
        @(negedge clk); check("R10 forced shutdown auto clear", bus_rdata, 16'h0000);
        step(); bus_rd = 0;
        // priority of auto clear over same-cycle set
        wr(12'h000, 16'h0100);
        wr(12'h000, 16'h0001);
        wr(12'h000, 16'h0200);
        rd_check(12'h000, 16'h0000, "R10 auto clear beats set");
        wr(12'h000, 16'h0200);
        rd_check(12'h000, 16'h0002, "R4 set while enable off");
        // enable set while asleep
        sleep_mode = 1; step();
        wr(12'h000, 16'h0100);
        rd_check(12'h000, 16'h0003, "R7 set during sleep keeps flag low");
        sleep_mode = 0; step();
        rd_check(12'h000, 16'h8003, "R8 release after set during sleep");
        bus_addr = 12'h1A0; bus_wr = 1;
        @(negedge clk); check("R9 open write forwarded", {15'b0, buf_wr_en}, 16'h1); step(); bus_wr = 0;
        step(); step();
        finish_run();
    end
endmodule